// File: doc/BRIEF.md
# Memory-mapped GPIO port with mask-based set, clear and toggle

The block is one general-purpose I/O port of up to 32 pins, reached over a plain register bus made of a word address, a write enable, write data and combinational read data. Software selects each pin's mode through a direction register. It drives the pins through an output data register and reads the pin levels through a sampled input register. Next to the read/write output register there are three write-only strobe addresses. A single bus write to one of them forces selected output bits high, forces them low or inverts them. No read-modify-write sequence is needed, so two agents that own different pins never disturb each other.

The pads are modelled as three separate vectors: the driven value, the output enable and the sampled level. The output register drives the pad value even while a pin is an input. Software can therefore preload a level through the set or clear strobe and then turn on the driver, and the pin shows the preloaded level from its first driven cycle. Pin levels pass through a two-stage synchronizer and then a capture register before software can read them.

Register map, word addresses: 0 direction (read/write), 1 output data (read/write), 2 input data (read-only), 3 set strobe, 4 clear strobe, 5 toggle strobe (all write-only), 6 and 7 unmapped.

Top module: `gpio_bank`

## Requirements
- R1: After a cycle with `rst` high, the direction and output data registers are zero, so `pad_oe` and `pad_out` are all zero and every pin is an input.
- R2: A write to address 0 loads the direction register from `bus_wdata` on the next clock edge; bit value 1 makes the pin an output and 0 an input; `pad_oe` equals the direction register, and reading address 0 returns it.
- R3: A write to address 1 replaces all output data bits at once on the next edge; `pad_out` equals the output data register, and reading address 1 returns it.
- R4: A write of a mask to address 3 sets the output bits at the mask's 1 positions and leaves the other output bits unchanged.
- R5: A write of a mask to address 4 clears the output bits at the mask's 1 positions and leaves the other output bits unchanged.
- R6: A write of a mask to address 5 inverts the output bits at the mask's 1 positions and leaves the other output bits unchanged.
- R7: Reads of addresses 3, 4, 5, 6 and 7 return zero. Writes to address 2, 6 or 7 change neither the direction nor the output data register, and cycles without a write leave both registers unchanged.
- R8: A level on `pad_in` that is stable from before rising edge k is returned by a read of address 2 once edge k+2 has passed, and not earlier. It goes through two synchronizer stages and the capture register.
- R9: `pad_out` follows the output data register even while the pin's direction bit is 0. An output level preloaded with the set or clear strobe therefore appears on the pin in the same cycle that its `pad_oe` bit rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | PIN_W | Write data or bit mask |
| bus_rdata | output | PIN_W | Read data for `bus_addr`, combinational |
| pad_in | input | PIN_W | Asynchronous pin levels |
| pad_out | output | PIN_W | Value driven on each pin |
| pad_oe | output | PIN_W | Output enable for each pin, 1 means driving |

## Verification
The bench builds the port with PIN_W = 12, a width that is not a power of two. Full-word writes, all-ones masks and every pad vector can then be spread across the whole port without touching a 32-bit boundary case. The width still leaves room for masks whose set and clear bits interleave with the bits already set. At this width a long run of random strobe, write and read traffic, together with randomly changing pad levels, covers all addresses, the unmapped ones included, many times. The per-cycle reference model judges the exact cycle in which the three-edge input latency lets a new pad level show.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR = 3'd0,
        SEL_OUT = 3'd1,
        SEL_IN  = 3'd2,
        SEL_SET = 3'd3,
        SEL_CLR = 3'd4,
        SEL_TGL = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic dir_we;
        logic out_we;
        logic set_we;
        logic clr_we;
        logic tgl_we;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic [ADDR_W-1:0] addr,
                                             input logic we);
        wr_cmd_t c;
        c.dir_we = we && (addr == SEL_DIR);
        c.out_we = we && (addr == SEL_OUT);
        c.set_we = we && (addr == SEL_SET);
        c.clr_we = we && (addr == SEL_CLR);
        c.tgl_we = we && (addr == SEL_TGL);
        return c;
    endfunction

    function automatic logic any_write(input wr_cmd_t c);
        return c.dir_we | c.out_we | c.set_we | c.clr_we | c.tgl_we;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] in_q
);
    logic [PIN_W-1:0] meta_q;
    logic [PIN_W-1:0] safe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            safe_q <= '0;
            in_q   <= '0;
        end else begin
            meta_q <= pad_in;
            safe_q <= meta_q;
            in_q   <= safe_q;
        end
    end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] out_q
);
    logic [PIN_W-1:0] out_d;

    for (genvar b = 0; b < PIN_W; b++) begin : g_bit
        always_comb begin
            out_d[b] = out_q[b];
            if (cmd.out_we)                  out_d[b] = wdata[b];
            else if (cmd.set_we && wdata[b]) out_d[b] = 1'b1;
            else if (cmd.clr_we && wdata[b]) out_d[b] = 1'b0;
            else if (cmd.tgl_we && wdata[b]) out_d[b] = ~out_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (cmd.dir_we) dir_q <= wdata;
            out_q <= out_d;
        end
    end

    p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.dir_we |=> (dir_q == $past(wdata)));

    p_set_mask_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.set_we |=> (((out_q & $past(wdata)) == $past(wdata)) &&
                        ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

    p_clr_mask_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.clr_we |=> (((out_q & $past(wdata)) == '0) &&
                        ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

    p_tgl_mask_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.tgl_we |=> (out_q == ($past(out_q) ^ $past(wdata))));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !any_write(cmd) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  dir_q,
    input  logic [PIN_W-1:0]  out_q,
    input  logic [PIN_W-1:0]  in_q,
    output logic [PIN_W-1:0]  rdata
);
    always_comb begin
        case (addr)
            SEL_DIR: rdata = dir_q;
            SEL_OUT: rdata = out_q;
            SEL_IN:  rdata = in_q;
            default: rdata = '0;
        endcase
    end

    p_wo_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (addr > SEL_IN) |-> (rdata == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe
);
    wr_cmd_t          cmd;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] out_q;
    logic [PIN_W-1:0] in_q;

    assign cmd = decode_write(bus_addr, bus_we);

    gpio_bank_ctl #(.PIN_W(PIN_W)) u_ctl (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata),
        .dir_q(dir_q), .out_q(out_q)
    );

    gpio_bank_sync #(.PIN_W(PIN_W)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .in_q(in_q)
    );

    gpio_bank_rdmux #(.PIN_W(PIN_W)) u_rd (
        .clk(clk), .rst(rst), .addr(bus_addr), .dir_q(dir_q),
        .out_q(out_q), .in_q(in_q), .rdata(bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = out_q;

    p_cmd_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> ((pad_oe == '0) && (pad_out == '0)));

    p_ro_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == SEL_IN)) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/100ps
module sim_gpio_bank;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_out = '0;
    logic [W-1:0] pin_hist[$];

    always #2.5 clk = ~clk;

    gpio_bank #(.PIN_W(W)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] m_in();
        return (pin_hist.size() == 3) ? pin_hist[0] : '0;
    endfunction

    function automatic logic [W-1:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_out;
            3'd2: return m_in();
            default: return '0;
        endcase
    endfunction

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_dir = '0;
            m_out = '0;
            pin_hist.delete();
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_dir = bus_wdata;
                    3'd1: m_out = bus_wdata;
                    3'd3: m_out = m_out | bus_wdata;
                    3'd4: m_out = m_out & ~bus_wdata;
                    3'd5: m_out = m_out ^ bus_wdata;
                    default: ;
                endcase
            end
            pin_hist.push_back(pad_in);
            if (pin_hist.size() > 3) void'(pin_hist.pop_front());
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // per-cycle comparison, just after the falling edge
    always @(negedge clk) begin
        #0.5;
        if (!rst && !done) begin
            chk(cur_req, "pad_oe", pad_oe, m_dir);
            chk(cur_req, "pad_out", pad_out, m_out);
            chk(cur_req, "bus_rdata", bus_rdata, m_rd(bus_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_sel(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1", "pad_oe after reset", pad_oe, '0);
        chk("R1", "pad_out after reset", pad_out, '0);

        cur_req = "R2";
        wr(3'd0, 12'h0F0); rd_sel(3'd0); settle();
        chk("R2", "pad_oe", pad_oe, 12'h0F0);
        chk("R2", "dir read", bus_rdata, 12'h0F0);

        cur_req = "R9";
        wr(3'd3, 12'h00F); settle();
        chk("R9", "preload while input", pad_out & 12'h00F, 12'h00F);
        chk("R9", "oe still low", pad_oe & 12'h00F, 12'h000);
        wr(3'd0, 12'h0FF); settle();
        chk("R9", "driven preload", pad_out & pad_oe & 12'h00F, 12'h00F);

        cur_req = "R3";
        wr(3'd1, 12'hA5A); rd_sel(3'd1); settle();
        chk("R3", "out read", bus_rdata, 12'hA5A);
        chk("R3", "pad_out", pad_out, 12'hA5A);

        cur_req = "R4";
        wr(3'd3, 12'h101); settle();
        chk("R4", "set mask", pad_out, 12'hB5B);

        cur_req = "R5";
        wr(3'd4, 12'h00F); settle();
        chk("R5", "clear mask", pad_out, 12'hB50);

        cur_req = "R6";
        wr(3'd5, 12'hFF0); settle();
        chk("R6", "toggle mask", pad_out, 12'h4A0);
        wr(3'd5, 12'hFFF); settle();
        chk("R6", "toggle all", pad_out, 12'hB5F);

        cur_req = "R7";
        for (int a = 3; a < 8; a++) begin
            rd_sel(3'(a)); settle();
            chk("R7", "write-only/unmapped read", bus_rdata, '0);
        end
        wr(3'd2, 12'hFFF); wr(3'd6, 12'h000); wr(3'd7, 12'hFFF); settle();
        chk("R7", "out after ignored writes", pad_out, 12'hB5F);
        chk("R7", "dir after ignored writes", pad_oe, 12'h0FF);

        cur_req = "R8";
        rd_sel(3'd2);
        settle();
        pad_in = 12'h3C5;
        @(negedge clk); #1;
        chk("R8", "input after 1 edge", bus_rdata, 12'h000);
        @(negedge clk); #1;
        chk("R8", "input after 2 edges", bus_rdata, 12'h000);
        @(negedge clk); #1;
        chk("R8", "input after 3 edges", bus_rdata, 12'h3C5);

        cur_req = "R4/R5/R6 random";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bus_addr  = 3'($urandom_range(0, 7));
            bus_we    = 1'($urandom_range(0, 1));
            bus_wdata = W'($urandom);
            if ($urandom_range(0, 3) == 0) pad_in = W'($urandom);
        end
        @(negedge clk);
        bus_we = 1'b0;
        settle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule